// File: doc/BRIEF.md
# Branch and jump next-PC selector

This block sits in the execute stage of a five-stage 32-bit integer pipeline. It decides where the next program counter is taken from. It looks at three things: a 2-bit control-transfer kind, the funct3 field of a conditional branch, and a packed 2-bit comparison flag from the ALU. From these it drives a 2-bit select for a three-input next-PC multiplexer. The three sources are the sequential address PC+4, the PC-relative target PC+immediate, and the register-indirect target taken from the ALU result. A redirect flag goes high with every non-sequential select, and the fetch and decode flush logic consumes it.

The ALU supplies the comparison flag. Bit 0 means the operands are equal. Bit 1 means the first operand is greater than the second, compared as signed values. The project also contains the flag generator and the next-PC multiplexer, so the bench can exercise the whole redirect path. Both are separate modules, and the selector itself is purely combinational.

Top module: `pc_redirect_sel`

## Requirements
- R1: When the kind code is 00 (plain instruction), the select is 00 (PC+4) and redirect is 0, whatever the funct3 and flag inputs are.
- R2: When the kind code is 10 (direct jump), the select is 01 (PC+immediate) and redirect is 1, whatever the funct3 and flag inputs are.
- R3: When the kind code is 11 (register jump), the select is 10 (ALU result) and redirect is 1, whatever the funct3 and flag inputs are.
- R4: For kind 01 (branch) with funct3 000 (equal), the branch is taken exactly when flag bit 0 is 1.
- R5: For kind 01 with funct3 001 (not equal), the branch is taken exactly when flag bit 0 is 0.
- R6: For kind 01 with funct3 100 (signed less-than), the branch is taken exactly when both flag bits are 0.
- R7: For kind 01 with funct3 101 (signed greater-or-equal), the branch is taken exactly when either flag bit is 1.
- R8: For kind 01 with any other funct3 value, the branch is never taken.
- R9: A taken branch gives select 01. A branch that is not taken gives select 00.
- R10: Redirect is 1 exactly when the select is not 00, and the select never takes the value 11.
- R11: The flag generator sets bit 0 when its operands are equal. It sets bit 1 when operand a is greater than operand b, both read as two's-complement numbers.
- R12: The next-PC multiplexer outputs PC+4 for select 00, PC+immediate for 01, and the ALU result with bit 0 cleared for 10. Select 11 falls back to PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| jump_kind_i | input | 2 | Control-transfer kind: 00 plain, 01 branch, 10 direct jump, 11 register jump |
| br_funct3_i | input | 3 | Branch condition field of the instruction in execute |
| cmp_flag_i | input | 2 | ALU comparison flag: bit 0 equal, bit 1 signed greater-than |
| pc_sel_o | output | 2 | Next-PC source select: 00 PC+4, 01 PC+immediate, 10 ALU result |
| redirect_o | output | 1 | High when the next PC is not sequential; drives the flush logic |

## Verification
Two functions can be active in the same cycle. The branch condition evaluator can report a met condition while the kind code says direct or register jump, and the jump must win. The same applies when funct3 and the flags describe a satisfied branch under a plain kind code, where the sequential path must hold. The bench provokes every such overlap by sweeping all 128 combinations of kind, funct3 and flag. For each one it compares select and redirect against a value it works out from the condition table. It also drives generated flags through the comparator, selector and multiplexer together, and checks the final next-PC address.

// File: rtl/pcsel_pkg.sv
package pcsel_pkg;

  typedef enum logic [1:0] {
    JK_PLAIN  = 2'b00,
    JK_BRANCH = 2'b01,
    JK_JAL    = 2'b10,
    JK_JALR   = 2'b11
  } jump_kind_e;

  typedef enum logic [1:0] {
    PCS_SEQ = 2'b00,
    PCS_REL = 2'b01,
    PCS_REG = 2'b10,
    PCS_RSV = 2'b11
  } pc_src_e;

  localparam logic [2:0] F3_EQ = 3'b000;
  localparam logic [2:0] F3_NE = 3'b001;
  localparam logic [2:0] F3_LT = 3'b100;
  localparam logic [2:0] F3_GE = 3'b101;

  localparam int FLAG_EQ_BIT = 0;
  localparam int FLAG_GT_BIT = 1;

  // Branch condition from the packed comparison flag.
  function automatic logic cond_met(input logic [2:0] f3, input logic [1:0] flg);
    logic eq, gt;
    eq = flg[FLAG_EQ_BIT];
    gt = flg[FLAG_GT_BIT];
    case (f3)
      F3_EQ:   cond_met = eq;
      F3_NE:   cond_met = !eq;
      F3_LT:   cond_met = !(eq || gt);
      F3_GE:   cond_met = eq || gt;
      default: cond_met = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cmp_flag_gen.sv
module cmp_flag_gen #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [1:0]       flag_o
);
  import pcsel_pkg::*;

  logic signed [WIDTH-1:0] a_s, b_s;

  always_comb begin
    a_s = a_i;
    b_s = b_i;
    flag_o = '0;
    flag_o[FLAG_EQ_BIT] = (a_i == b_i);
    flag_o[FLAG_GT_BIT] = (a_s > b_s);
  end
endmodule

// File: rtl/next_pc_mux.sv
module next_pc_mux #(
  parameter int XLEN = 32
) (
  input  logic [1:0]      sel_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [XLEN-1:0] alu_res_i,
  output logic [XLEN-1:0] next_pc_o
);
  import pcsel_pkg::*;

  localparam logic [XLEN-1:0] STEP     = XLEN'(4);
  localparam logic [XLEN-1:0] LSB_MASK = ~XLEN'(1);

  always_comb begin
    case (pc_src_e'(sel_i))
      PCS_REL: next_pc_o = pc_i + imm_i;
      PCS_REG: next_pc_o = alu_res_i & LSB_MASK;
      default: next_pc_o = pc_i + STEP;
    endcase
  end
endmodule

// File: rtl/brcond_eval.sv
module brcond_eval (
  input  logic [2:0] funct3_i,
  input  logic [1:0] flag_i,
  output logic       met_o
);
  import pcsel_pkg::*;

  always_comb met_o = cond_met(funct3_i, flag_i);
endmodule

// File: rtl/pcsel_encode.sv
module pcsel_encode (
  input  logic [1:0] jump_kind_i,
  input  logic       cond_met_i,
  output logic [1:0] pc_sel_o
);
  import pcsel_pkg::*;

  always_comb begin
    case (jump_kind_e'(jump_kind_i))
      JK_JAL:    pc_sel_o = PCS_REL;
      JK_JALR:   pc_sel_o = PCS_REG;
      JK_BRANCH: pc_sel_o = cond_met_i ? PCS_REL : PCS_SEQ;
      default:   pc_sel_o = PCS_SEQ;
    endcase
  end
endmodule

// File: rtl/pc_redirect_sel.sv
module pc_redirect_sel (
  input  logic [1:0] jump_kind_i,
  input  logic [2:0] br_funct3_i,
  input  logic [1:0] cmp_flag_i,
  output logic [1:0] pc_sel_o,
  output logic       redirect_o
);
  import pcsel_pkg::*;

  logic branch_met;
  logic is_jump;
  logic is_branch;

  brcond_eval u_cond (
    .funct3_i (br_funct3_i),
    .flag_i   (cmp_flag_i),
    .met_o    (branch_met)
  );

  pcsel_encode u_enc (
    .jump_kind_i (jump_kind_i),
    .cond_met_i  (branch_met),
    .pc_sel_o    (pc_sel_o)
  );

  // Redirect is formed from the kind code directly, not from the select.
  always_comb begin
    is_jump    = jump_kind_i[1];
    is_branch  = (jump_kind_i == JK_BRANCH);
    redirect_o = is_jump || (is_branch && branch_met);
  end
endmodule

// File: rtl/pc_redirect_sel_chk.sv
module pc_redirect_sel_chk (
  input logic [1:0] jump_kind,
  input logic [2:0] funct3,
  input logic [1:0] flag,
  input logic [1:0] pc_sel,
  input logic       redirect,
  input logic       cond_met
);
  always_comb begin
    // R1
    plain_seq_chk: assert (jump_kind != 2'b00 || (pc_sel == 2'b00 && !redirect));
    // R2
    jal_rel_chk: assert (jump_kind != 2'b10 || pc_sel == 2'b01);
    // R3
    jalr_reg_chk: assert (jump_kind != 2'b11 || pc_sel == 2'b10);
    // R9
    branch_sel_chk: assert (jump_kind != 2'b01 || pc_sel == {1'b0, cond_met});
    // R6
    blt_cond_chk: assert (jump_kind != 2'b01 || funct3 != 3'b100 || redirect == (flag == 2'b00));
    // R8
    bad_funct3_chk: assert (jump_kind != 2'b01 || funct3[2:1] == 2'b00 || funct3[2:1] == 2'b10 || !redirect);
    // R10
    redirect_match_chk: assert (redirect == (pc_sel != 2'b00));
    // R10
    sel_legal_chk: assert (pc_sel != 2'b11);
  end
endmodule

bind pc_redirect_sel pc_redirect_sel_chk u_chk (
  .jump_kind (jump_kind_i),
  .funct3    (br_funct3_i),
  .flag      (cmp_flag_i),
  .pc_sel    (pc_sel_o),
  .redirect  (redirect_o),
  .cond_met  (branch_met)
);

// File: tb/pc_redirect_sel_tb.sv
module pc_redirect_sel_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [1:0] kind;
  logic [2:0] f3;
  logic [1:0] flg;
  logic [1:0] sel;
  logic       redir;

  logic [31:0] op_a, op_b;
  logic [1:0]  gen_flag;
  logic [1:0]  path_sel;
  logic        path_redir;
  logic [31:0] pc, imm, alu;
  logic [1:0]  mux_sel;
  logic [31:0] npc;

  pc_redirect_sel dut_i (
    .jump_kind_i (kind), .br_funct3_i (f3), .cmp_flag_i (flg),
    .pc_sel_o (sel), .redirect_o (redir)
  );

  cmp_flag_gen #(.WIDTH(32)) cmp_i (.a_i(op_a), .b_i(op_b), .flag_o(gen_flag));

  pc_redirect_sel path_i (
    .jump_kind_i (2'b01), .br_funct3_i (f3), .cmp_flag_i (gen_flag),
    .pc_sel_o (path_sel), .redirect_o (path_redir)
  );

  next_pc_mux #(.XLEN(32)) mux_i (
    .sel_i (mux_sel), .pc_i (pc), .imm_i (imm), .alu_res_i (alu), .next_pc_o (npc)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (kind=%b f3=%b flag=%b)", req, got, exp, kind, f3, flg);
    end
  endtask

  function automatic string req_of(input logic [1:0] k, input logic [2:0] f);
    if (k == 2'b00) return "R1";
    if (k == 2'b10) return "R2";
    if (k == 2'b11) return "R3";
    case (f)
      3'b000: return "R4";
      3'b001: return "R5";
      3'b100: return "R6";
      3'b101: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Expected branch outcome, reasoned from the signed order of the operands.
  function automatic logic exp_taken(input logic [2:0] f, input logic [1:0] fl);
    int order;   // -1 less, 0 equal, 1 greater
    order = fl[0] ? 0 : (fl[1] ? 1 : -1);
    if (f == 3'b000) return order == 0;
    if (f == 3'b001) return order != 0;
    if (f == 3'b100) return order < 0;
    if (f == 3'b101) return order >= 0;
    return 1'b0;
  endfunction

  logic [31:0] vals [6];

  initial begin
    kind = 2'b00; f3 = 3'b000; flg = 2'b11;
    op_a = '0; op_b = '0; pc = '0; imm = '0; alu = '0; mux_sel = 2'b00;
    @(negedge clk);
    check("R1 idle state", {30'd0, sel}, 32'd0);
    check("R10 idle redirect", {31'd0, redir}, 32'd0);

    // Full sweep of the selector: all kinds, funct3 values and flags.
    for (int k = 0; k < 4; k++) begin
      for (int f = 0; f < 8; f++) begin
        for (int g = 0; g < 4; g++) begin
          logic [1:0] es;
          kind = 2'(k); f3 = 3'(f); flg = 2'(g);
          @(negedge clk);
          if (k == 0)      es = 2'd0;
          else if (k == 2) es = 2'd1;
          else if (k == 3) es = 2'd2;
          else             es = exp_taken(3'(f), 2'(g)) ? 2'd1 : 2'd0;
          check({req_of(2'(k), 3'(f)), " R9 select"}, {30'd0, sel}, {30'd0, es});
          check("R10 redirect", {31'd0, redir}, {31'd0, es != 2'd0});
        end
      end
    end

    // Comparator and branch path with signed corner operands.
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        longint sa, sb;
        op_a = vals[i]; op_b = vals[j];
        sa = longint'($signed(vals[i])); sb = longint'($signed(vals[j]));
        f3 = 3'b100;
        @(negedge clk);
        check("R11 equal bit", {31'd0, gen_flag[0]}, {31'd0, sa == sb});
        check("R11 greater bit", {31'd0, gen_flag[1]}, {31'd0, sa > sb});
        check("R6 less-than path", {31'd0, path_redir}, {31'd0, sa < sb});
        f3 = 3'b101;
        @(negedge clk);
        check("R7 greater-equal path", {31'd0, path_redir}, {31'd0, sa >= sb});
        f3 = 3'b001;
        @(negedge clk);
        check("R5 not-equal path", {31'd0, path_redir}, {31'd0, sa != sb});
      end
    end

    // Next-PC multiplexer.
    for (int t = 0; t < 3; t++) begin
      pc  = 32'h0000_1000 + 32'(t * 32'h0123_4560);
      imm = (t == 1) ? 32'hFFFF_FFF0 : 32'h0000_0040 + 32'(t);
      alu = 32'h0000_2001 + 32'(t * 7);
      for (int s = 0; s < 4; s++) begin
        logic [31:0] en;
        mux_sel = 2'(s);
        @(negedge clk);
        case (s)
          1: en = pc + imm;
          2: en = {alu[31:1], 1'b0};
          default: en = pc + 32'd4;
        endcase
        check("R12 next pc", npc, en);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule